// File: doc/BRIEF.md
# Timer Configuration Register Bank with Enable Lock

This block holds the configuration of a timer/counter peripheral and presents every field as a steady output to the counting, prescaling and waveform logic. Software reaches it through a plain synchronous port: an address, a write word and a write strobe, with read data returned combinationally for the presented address. A write takes effect at the rising clock edge on which the strobe is high.

Part of the configuration is locked while the timer runs. Four whole registers (two fault-handling words, a waveform-extension word and an event-routing word) and the drive register with its per-channel output-invert bits accept writes only while the run bit is low. Inside the main control word, the prescaler select, prescaler sync mode and per-channel capture enables are locked in the same way. The run, standby-run and soft-reset bits stay writable at all times. A write that turns the run bit on from off also loads the locked control fields. A write that turns it off leaves them as they were. Counting direction is changed through a separate set address and clear address. A rejected write raises a one-cycle flag.

Top module: `tmr_cfg_bank`

## Requirements
- R1: After synchronous reset every field output is 0, `wr_ignored` is 0 and every address reads 0.
- R2: While `enable` is 0, a write to address 1 (fault word A), 2 (fault word B), 3 (waveform extension), 4 (drive word) or 5 (event word) stores all 16 bits. The value is visible on the matching output and on read from the next cycle.
- R3: While `enable` is 1, a write to addresses 1 to 5 is ignored and the stored word and its output stay unchanged.
- R4: Control word (address 0) bit 1 is the run bit `enable` and bit 2 is `run_stby`. A control write with bit 0 low updates both in any state.
- R5: Control bits [5:3] (`presc_sel`), [7:6] (`presc_sync`) and [11:8] (`capt_en`) are loaded by a control write only if `enable` was 0 before the write. They keep their value when the write clears `enable`.
- R6: A control write that sets bit 1 while `enable` is 0 loads bits [11:3] from that same write.
- R7: A control write with bit 0 set returns every register, including `enable`, `wave_cfg` and `count_down`, to 0 at that edge. Control bit 0 always reads 0.
- R8: Writing address 7 with bit 0 set sets `count_down`. Writing address 8 with bit 0 set clears it. Bit 0 low at either address changes nothing. Both addresses read `count_down` in bit 0.
- R9: `wr_ignored` is high for exactly the cycle after a rejected write. A write is rejected if it goes to addresses 1 to 5 while `enable` is 1, or if it is a control write with bit 0 low while `enable` is 1 whose bits [11:3] differ from the stored values.
- R10: Address 6 (`wave_cfg`, 16 bits) is writable in any state.
- R11: `inv_en` shows bits [3:0] of the drive word. Control bits [15:12] read 0. Addresses 9 to 15 hold nothing and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address for read and write |
| bus_wdata | input | 16 | Write word |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 16 | Read word for `bus_addr` (combinational) |
| wr_ignored | output | 1 | One-cycle pulse after a rejected write |
| enable | output | 1 | Run bit |
| run_stby | output | 1 | Keep running in standby |
| presc_sel | output | 3 | Prescaler select |
| presc_sync | output | 2 | Prescaler sync mode |
| capt_en | output | 4 | Per-channel capture enable |
| fault_a | output | 16 | Fault handling word A |
| fault_b | output | 16 | Fault handling word B |
| wave_ext | output | 16 | Waveform extension word |
| inv_en | output | 4 | Per-channel output invert |
| ev_ctl | output | 16 | Event routing word |
| wave_cfg | output | 16 | Waveform mode word |
| count_down | output | 1 | Counting direction, 1 = down |

## Verification
All field outputs and `wr_ignored` are one register stage from the bus, so a write launched on one edge shows its result from that edge until the next one. The read path adds no stage: `bus_rdata` follows `bus_addr` within the same cycle. The bench drives each write in the low clock phase and lifts the strobe at the following falling edge. It checks `wr_ignored` and the field outputs just after that falling edge, then presents each read address in a later low phase, so every check lands one edge after its stimulus. The pulse width is checked by sampling again one cycle later.

// File: rtl/tmrcfg_pkg.sv
package tmrcfg_pkg;

    parameter int DATA_W  = 16;
    parameter int ADDR_W  = 4;
    parameter int CH_N    = 4;
    parameter int PRESC_W = 3;
    parameter int SYNC_W  = 2;
    parameter int NPROT   = 5;

    // control word layout
    localparam int BIT_SWRST = 0;
    localparam int BIT_EN    = 1;
    localparam int BIT_STBY  = 2;
    localparam int LSB_PRESC = 3;
    localparam int LSB_SYNC  = LSB_PRESC + PRESC_W;
    localparam int LSB_CAPT  = LSB_SYNC + SYNC_W;
    localparam int CTRL_USED = LSB_CAPT + CH_N;

    // address map
    localparam int A_CTRL    = 0;
    localparam int A_PROT_LO = 1;
    localparam int A_PROT_HI = A_PROT_LO + NPROT - 1;
    localparam int A_WAVE    = A_PROT_HI + 1;
    localparam int A_DIRSET  = A_WAVE + 1;
    localparam int A_DIRCLR  = A_DIRSET + 1;

    localparam logic [DATA_W-1:0] PROT_MASK =
        DATA_W'(((1 << (CTRL_USED - LSB_PRESC)) - 1) << LSB_PRESC);

    typedef struct packed {
        logic [CH_N-1:0]    capt;
        logic [SYNC_W-1:0]  sync;
        logic [PRESC_W-1:0] presc;
    } ctrl_prot_t;

    typedef struct packed {
        logic run_stby;
        logic enable;
    } ctrl_free_t;

    typedef struct packed {
        logic             swrst;
        logic             ctrl_free_we;
        logic             ctrl_prot_we;
        logic [NPROT-1:0] prot_we;
        logic             wave_we;
        logic             dir_set;
        logic             dir_clr;
        logic             ignored;
    } wr_cmd_t;

    function automatic logic [ADDR_W-1:0] ra(input int a);
        return a[ADDR_W-1:0];
    endfunction

    function automatic ctrl_prot_t prot_from_word(input logic [DATA_W-1:0] w);
        ctrl_prot_t p;
        p.presc = w[LSB_PRESC +: PRESC_W];
        p.sync  = w[LSB_SYNC  +: SYNC_W];
        p.capt  = w[LSB_CAPT  +: CH_N];
        return p;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_word(input ctrl_free_t f,
                                                   input ctrl_prot_t p);
        logic [DATA_W-1:0] w;
        w                       = '0;
        w[BIT_EN]               = f.enable;
        w[BIT_STBY]             = f.run_stby;
        w[LSB_PRESC +: PRESC_W] = p.presc;
        w[LSB_SYNC  +: SYNC_W]  = p.sync;
        w[LSB_CAPT  +: CH_N]    = p.capt;
        return w;
    endfunction

endpackage

// File: rtl/tmrcfg_gate.sv
module tmrcfg_gate
    import tmrcfg_pkg::*;
(
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                enable_q,
    input  ctrl_prot_t          prot_q,
    output wr_cmd_t             cmd
);

    logic prot_differs;
    assign prot_differs = ((bus_wdata & PROT_MASK) !=
                           (ctrl_word('0, prot_q) & PROT_MASK));

    always_comb begin
        cmd = '0;
        if (bus_wr) begin
            if (bus_addr == ra(A_CTRL)) begin
                if (bus_wdata[BIT_SWRST]) begin
                    cmd.swrst = 1'b1;
                end else begin
                    cmd.ctrl_free_we = 1'b1;
                    if (!enable_q)
                        cmd.ctrl_prot_we = 1'b1;
                    else if (prot_differs)
                        cmd.ignored = 1'b1;
                end
            end else if (bus_addr >= ra(A_PROT_LO) && bus_addr <= ra(A_PROT_HI)) begin
                if (enable_q) begin
                    cmd.ignored = 1'b1;
                end else begin
                    for (int i = 0; i < NPROT; i++)
                        if (bus_addr == ra(A_PROT_LO + i))
                            cmd.prot_we[i] = 1'b1;
                end
            end else if (bus_addr == ra(A_WAVE)) begin
                cmd.wave_we = 1'b1;
            end else if (bus_addr == ra(A_DIRSET)) begin
                cmd.dir_set = bus_wdata[0];
            end else if (bus_addr == ra(A_DIRCLR)) begin
                cmd.dir_clr = bus_wdata[0];
            end
        end
    end

endmodule

// File: rtl/tmrcfg_store.sv
module tmrcfg_store
    import tmrcfg_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  wr_cmd_t                      cmd,
    input  logic [DATA_W-1:0]            bus_wdata,
    output ctrl_free_t                   free_q,
    output ctrl_prot_t                   prot_q,
    output logic [NPROT-1:0][DATA_W-1:0] lock_q,
    output logic [DATA_W-1:0]            wave_q,
    output logic                         dir_q,
    output logic                         ign_q
);

    logic clr;
    assign clr = rst || cmd.swrst;

    always_ff @(posedge clk) begin
        if (clr) begin
            free_q <= '0;
        end else if (cmd.ctrl_free_we) begin
            free_q.enable   <= bus_wdata[BIT_EN];
            free_q.run_stby <= bus_wdata[BIT_STBY];
        end
    end

    always_ff @(posedge clk) begin
        if (clr)
            prot_q <= '0;
        else if (cmd.ctrl_prot_we)
            prot_q <= prot_from_word(bus_wdata);
    end

    for (genvar g = 0; g < NPROT; g++) begin : g_lock
        always_ff @(posedge clk) begin
            if (clr)
                lock_q[g] <= '0;
            else if (cmd.prot_we[g])
                lock_q[g] <= bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (clr)
            wave_q <= '0;
        else if (cmd.wave_we)
            wave_q <= bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (clr)
            dir_q <= 1'b0;
        else if (cmd.dir_set)
            dir_q <= 1'b1;
        else if (cmd.dir_clr)
            dir_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ign_q <= 1'b0;
        else
            ign_q <= cmd.ignored;
    end

endmodule

// File: rtl/tmrcfg_rdmux.sv
module tmrcfg_rdmux
    import tmrcfg_pkg::*;
(
    input  logic [ADDR_W-1:0]            bus_addr,
    input  ctrl_free_t                   free_q,
    input  ctrl_prot_t                   prot_q,
    input  logic [NPROT-1:0][DATA_W-1:0] lock_q,
    input  logic [DATA_W-1:0]            wave_q,
    input  logic                         dir_q,
    output logic [DATA_W-1:0]            bus_rdata
);

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ra(A_CTRL))
            bus_rdata = ctrl_word(free_q, prot_q);
        else if (bus_addr == ra(A_WAVE))
            bus_rdata = wave_q;
        else if (bus_addr == ra(A_DIRSET) || bus_addr == ra(A_DIRCLR))
            bus_rdata = DATA_W'(dir_q);
        else
            for (int i = 0; i < NPROT; i++)
                if (bus_addr == ra(A_PROT_LO + i))
                    bus_rdata = lock_q[i];
    end

endmodule

// File: rtl/tmr_cfg_bank.sv
module tmr_cfg_bank
    import tmrcfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_wr,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                wr_ignored,
    output logic                enable,
    output logic                run_stby,
    output logic [PRESC_W-1:0]  presc_sel,
    output logic [SYNC_W-1:0]   presc_sync,
    output logic [CH_N-1:0]     capt_en,
    output logic [DATA_W-1:0]   fault_a,
    output logic [DATA_W-1:0]   fault_b,
    output logic [DATA_W-1:0]   wave_ext,
    output logic [CH_N-1:0]     inv_en,
    output logic [DATA_W-1:0]   ev_ctl,
    output logic [DATA_W-1:0]   wave_cfg,
    output logic                count_down
);

    localparam int IX_FLT_A = 0;
    localparam int IX_FLT_B = 1;
    localparam int IX_WEXT  = 2;
    localparam int IX_DRIVE = 3;
    localparam int IX_EVENT = 4;

    wr_cmd_t                      cmd;
    ctrl_free_t                   free_q;
    ctrl_prot_t                   prot_q;
    logic [NPROT-1:0][DATA_W-1:0] lock_q;
    logic [DATA_W-1:0]            wave_q;
    logic                         dir_q;
    logic                         ign_q;

    tmrcfg_gate u_gate (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .enable_q  (free_q.enable),
        .prot_q    (prot_q),
        .cmd       (cmd)
    );

    tmrcfg_store u_store (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .bus_wdata (bus_wdata),
        .free_q    (free_q),
        .prot_q    (prot_q),
        .lock_q    (lock_q),
        .wave_q    (wave_q),
        .dir_q     (dir_q),
        .ign_q     (ign_q)
    );

    tmrcfg_rdmux u_rdmux (
        .bus_addr  (bus_addr),
        .free_q    (free_q),
        .prot_q    (prot_q),
        .lock_q    (lock_q),
        .wave_q    (wave_q),
        .dir_q     (dir_q),
        .bus_rdata (bus_rdata)
    );

    assign wr_ignored = ign_q;
    assign enable     = free_q.enable;
    assign run_stby   = free_q.run_stby;
    assign presc_sel  = prot_q.presc;
    assign presc_sync = prot_q.sync;
    assign capt_en    = prot_q.capt;
    assign fault_a    = lock_q[IX_FLT_A];
    assign fault_b    = lock_q[IX_FLT_B];
    assign wave_ext   = lock_q[IX_WEXT];
    assign inv_en     = lock_q[IX_DRIVE][CH_N-1:0];
    assign ev_ctl     = lock_q[IX_EVENT];
    assign wave_cfg   = wave_q;
    assign count_down = dir_q;

endmodule

// File: rtl/tmrcfg_chk.sv
module tmrcfg_chk
    import tmrcfg_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic                bus_wr,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic                wr_ignored,
    input logic                enable,
    input logic                run_stby,
    input logic [PRESC_W-1:0]  presc_sel,
    input logic [SYNC_W-1:0]   presc_sync,
    input logic [CH_N-1:0]     capt_en,
    input logic [DATA_W-1:0]   fault_a,
    input logic [DATA_W-1:0]   fault_b,
    input logic [DATA_W-1:0]   wave_ext,
    input logic [CH_N-1:0]     inv_en,
    input logic [DATA_W-1:0]   ev_ctl,
    input logic [DATA_W-1:0]   wave_cfg,
    input logic                count_down
);

    logic lock_hit, ctrl_hit;
    assign lock_hit = bus_wr && bus_addr >= ra(A_PROT_LO) && bus_addr <= ra(A_PROT_HI);
    assign ctrl_hit = bus_wr && bus_addr == ra(A_CTRL);

    // R3: locked words hold while running
    p_lock_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (enable && lock_hit) |=> ($stable(fault_a) && $stable(fault_b) &&
                                  $stable(wave_ext) && $stable(inv_en) && $stable(ev_ctl)));

    // R9: rejected write to a locked word raises the flag
    p_lock_flag_r9: assert property (@(posedge clk) disable iff (rst)
        (enable && lock_hit) |=> wr_ignored);

    // R9: no flag for any write while stopped
    p_no_flag_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (!enable && bus_wr) |=> !wr_ignored);

    // R5: locked control fields hold while running
    p_ctrl_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (enable && ctrl_hit && !bus_wdata[BIT_SWRST]) |=>
        ($stable(presc_sel) && $stable(presc_sync) && $stable(capt_en)));

    // R4: run and standby bits follow any control write
    p_free_bits_r4: assert property (@(posedge clk) disable iff (rst)
        (ctrl_hit && !bus_wdata[BIT_SWRST]) |=>
        (enable == $past(bus_wdata[BIT_EN]) && run_stby == $past(bus_wdata[BIT_STBY])));

    // R7: soft reset clears the whole bank
    p_soft_reset_r7: assert property (@(posedge clk) disable iff (rst)
        (ctrl_hit && bus_wdata[BIT_SWRST]) |=>
        (!enable && !run_stby && presc_sel == '0 && presc_sync == '0 && capt_en == '0 &&
         fault_a == '0 && fault_b == '0 && wave_ext == '0 && inv_en == '0 &&
         ev_ctl == '0 && wave_cfg == '0 && !count_down));

    // R8: direction set address
    p_dir_set_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ra(A_DIRSET) && bus_wdata[0]) |=> count_down);

    // R8: direction clear address
    p_dir_clr_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ra(A_DIRCLR) && bus_wdata[0]) |=> !count_down);

    // R11: unmapped addresses read zero
    p_unmapped_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_addr > ra(A_DIRCLR)) |-> (bus_rdata == '0));

endmodule

bind tmr_cfg_bank tmrcfg_chk u_chk (.*);

// File: tb/test_tmr_cfg_bank.sv
module test_tmr_cfg_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_rdata;
    logic        wr_ignored, enable, run_stby, count_down;
    logic [2:0]  presc_sel;
    logic [1:0]  presc_sync;
    logic [3:0]  capt_en, inv_en;
    logic [15:0] fault_a, fault_b, wave_ext, ev_ctl, wave_cfg;

    always #2.5 clk = ~clk;

    tmr_cfg_bank i_tmr_cfg_bank (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rdata(bus_rdata), .wr_ignored(wr_ignored),
        .enable(enable), .run_stby(run_stby), .presc_sel(presc_sel),
        .presc_sync(presc_sync), .capt_en(capt_en), .fault_a(fault_a),
        .fault_b(fault_b), .wave_ext(wave_ext), .inv_en(inv_en),
        .ev_ctl(ev_ctl), .wave_cfg(wave_cfg), .count_down(count_down)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference model
    logic        m_en, m_stby, m_dir, m_ign;
    logic [2:0]  m_presc;
    logic [1:0]  m_sync;
    logic [3:0]  m_capt;
    logic [15:0] m_lock [5];
    logic [15:0] m_wave;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        m_en = 0; m_stby = 0; m_dir = 0; m_ign = 0;
        m_presc = 0; m_sync = 0; m_capt = 0; m_wave = 0;
        for (int i = 0; i < 5; i++) m_lock[i] = 0;
    endtask

    function automatic logic [15:0] exp_read(input int a);
        case (a)
            0: return {4'b0, m_capt, m_sync, m_presc, m_stby, m_en, 1'b0};
            1, 2, 3, 4, 5: return m_lock[a-1];
            6: return m_wave;
            7, 8: return {15'b0, m_dir};
            default: return 16'h0;
        endcase
    endfunction

    task automatic model_write(input int a, input logic [15:0] d);
        m_ign = 0;
        if (a == 0) begin
            if (d[0]) begin
                model_clear();
            end else begin
                if (!m_en) begin
                    m_presc = d[5:3]; m_sync = d[7:6]; m_capt = d[11:8];
                end else if (d[11:3] != {m_capt, m_sync, m_presc}) begin
                    m_ign = 1;
                end
                m_en = d[1]; m_stby = d[2];
            end
        end else if (a >= 1 && a <= 5) begin
            if (m_en) m_ign = 1;
            else m_lock[a-1] = d;
        end else if (a == 6) begin
            m_wave = d;
        end else if (a == 7) begin
            if (d[0]) m_dir = 1;
        end else if (a == 8) begin
            if (d[0]) m_dir = 0;
        end
    endtask

    // write launched in the low phase, takes effect at the next rising edge;
    // results sampled just after the following falling edge
    task automatic do_write(input int a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a[3:0]; bus_wdata = d; bus_wr = 1'b1;
        model_write(a, d);
        @(negedge clk);
        bus_wr = 1'b0;
        #0.5;
        check("R9 flag", {31'b0, wr_ignored}, {31'b0, m_ign});
    endtask

    task automatic check_ports(input string tag);
        check({tag, " enable R4"},    {31'b0, enable},   {31'b0, m_en});
        check({tag, " stby R4"},      {31'b0, run_stby}, {31'b0, m_stby});
        check({tag, " presc R5"},     {29'b0, presc_sel},  {29'b0, m_presc});
        check({tag, " sync R5"},      {30'b0, presc_sync}, {30'b0, m_sync});
        check({tag, " capt R5"},      {28'b0, capt_en},    {28'b0, m_capt});
        check({tag, " fault_a R2"},   {16'b0, fault_a},  {16'b0, m_lock[0]});
        check({tag, " fault_b R2"},   {16'b0, fault_b},  {16'b0, m_lock[1]});
        check({tag, " wave_ext R2"},  {16'b0, wave_ext}, {16'b0, m_lock[2]});
        check({tag, " inv_en R11"},   {28'b0, inv_en},   {28'b0, m_lock[3][3:0]});
        check({tag, " ev_ctl R2"},    {16'b0, ev_ctl},   {16'b0, m_lock[4]});
        check({tag, " wave_cfg R10"}, {16'b0, wave_cfg}, {16'b0, m_wave});
        check({tag, " dir R8"},       {31'b0, count_down}, {31'b0, m_dir});
    endtask

    task automatic check_reads(input string tag);
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            bus_addr = a[3:0];
            #0.5;
            check($sformatf("%s read addr %0d", tag, a), {16'b0, bus_rdata}, {16'b0, exp_read(a)});
        end
    endtask

    function automatic logic [15:0] pattern(input int k, input int a);
        case (k)
            0: return 16'h0000;
            1: return 16'hFFFF;
            2: return 16'hA5A5;
            3: return 16'h5A5A;
            4: return 16'h0001;
            5: return 16'h8000;
            6: return 16'hFFFE;
            default: return 16'h1357 ^ 16'(a * 16'h0F0F);
        endcase
    endfunction

    function automatic string tag_for(input int a, input logic en);
        if (a >= 1 && a <= 5) return en ? "R3" : "R2";
        if (a == 6) return "R10";
        if (a == 7 || a == 8) return "R8";
        return "R11";
    endfunction

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        #0.5;
        check("R1 flag", {31'b0, wr_ignored}, 32'h0);
        check_ports("R1");
        check_reads("R1");

        // sweep every address and pattern, stopped then running (R2 R3 R8 R10 R11)
        for (int pass = 0; pass < 2; pass++) begin
            do_write(0, pass ? 16'h0002 : 16'h0000);
            for (int a = 1; a < 16; a++) begin
                if (a > 10 && a != 15) continue;
                for (int k = 0; k < 8; k++) begin
                    string t;
                    t = tag_for(a, m_en);
                    do_write(a, pattern(k, a));
                    check_ports(t);
                    check_reads(t);
                end
            end
        end

        // R9: pulse lasts one cycle
        do_write(1, 16'h1234);
        @(negedge clk); #0.5;
        check("R9 pulse width", {31'b0, wr_ignored}, 32'h0);

        // control word sweep over all bit 0-clear values (R4 R5 R6)
        do_write(0, 16'h0000);
        for (int v = 0; v < 4096; v += 2) begin
            logic was_en;
            logic [15:0] d;
            d = 16'(v) ^ 16'(((v >> 3) & 1) << 1);
            was_en = m_en;
            do_write(0, d);
            check_ports(was_en ? "R5 locked" : (d[1] ? "R6 start" : "R5 open"));
            @(negedge clk);
            bus_addr = 4'd0;
            #0.5;
            check("R6 ctrl read", {16'b0, bus_rdata}, {16'b0, exp_read(0)});
        end

        // R6: a write that starts the timer loads locked fields in the same write
        do_write(0, 16'h0000);
        do_write(0, 16'h0BAE);
        check("R6 start load presc", {29'b0, presc_sel}, {29'b0, 3'b101});
        check("R6 start load capt",  {28'b0, capt_en},   32'hB);
        // R5: clearing run keeps locked fields
        do_write(0, 16'h0000);
        check("R5 stop keeps sync", {30'b0, presc_sync}, {30'b0, 2'b10});
        check("R5 stop enable low", {31'b0, enable}, 32'h0);

        // R7: soft reset while running, then while stopped
        for (int r = 0; r < 2; r++) begin
            do_write(0, 16'h0000);
            for (int a = 1; a <= 6; a++) do_write(a, 16'hC3C3 ^ 16'(a));
            do_write(7, 16'h0001);
            do_write(0, r ? 16'h0FFC : 16'h0F7A);
            do_write(0, 16'hFFFF);
            check("R7 flag", {31'b0, wr_ignored}, 32'h0);
            check_ports("R7");
            check_reads("R7");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule